// File: doc/BRIEF.md
# Data Effective Address Sequencer

This block forms the effective address of a data operand for an 8-bit processor whose address space is 16 bits wide. A single-cycle `start` pulse captures the addressing mode, the one or two operand bytes, the two index register values and a read-modify-write flag. The sequencer then works through the mode: it adds an index, fetches a two-byte pointer from page zero through a byte-wide synchronous read port, or does both in the order the mode requires. When the address is ready, `done` pulses for one cycle while `ea` carries the result and `extra` reports the penalty cycles that were spent.

Page zero is the first 256 bytes of the space. Zero-page indexed sums and pointer fetches always wrap inside it. Absolute indexed and post-indexed sums carry into the high byte, and a carry that changes the high byte costs one penalty cycle. Pre-indexing applies the index before the pointer fetch and never pays that penalty. Post-indexing fetches the pointer first and adds the index afterwards. Instruction decode, arithmetic and the final data access happen outside this block.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done` and `mem_rd` are low, and `ea` and `extra` are zero.
- R2: Mode 0 (zero page) gives `ea` = {00, op_lo}. Mode 3 (absolute) gives `ea` = {op_hi, op_lo}. Both give `extra` = 0, and `done` is high in the 1st cycle after the cycle in which `start` is sampled.
- R3: Mode 1 (zero page + X) and mode 2 (zero page + Y) give `ea` = {00, (op_lo + index) mod 256}, with `extra` = 1. For example, base F0 plus 20 gives 0010.
- R4: Mode 4 (absolute + X) and mode 5 (absolute + Y) give `ea` = ({op_hi, op_lo} + index) mod 65536. `extra` is 1 exactly when the high byte of `ea` differs from op_hi. For example, 80C0 plus 80 gives 8140 with `extra` = 1.
- R5: When `rmw` is high, mode 4 always reports `extra` = 1. `rmw` has no effect in any other mode.
- R6: Modes 6, 7 and 8 perform exactly two reads, with `mem_rd` high in two consecutive cycles. The first read is at {00, p} and the second at {00, (p + 1) mod 256`}`, so a pointer at FF takes its high byte from 0000. `mem_data` must carry the addressed byte in the cycle after each read. No other mode reads.
- R7: Mode 6 (zero-page indirect) uses p = op_lo and gives `ea` = {second byte, first byte}, with `extra` = 0.
- R8: Mode 7 (pre-indexed indirect) uses p = (op_lo + X) mod 256 and gives `ea` = the fetched pointer, with `extra` = 0 in every case.
- R9: Mode 8 (post-indexed indirect) uses p = op_lo and gives `ea` = (pointer + Y) mod 65536. `extra` is 1 exactly when the high byte of `ea` differs from the high byte of the pointer.
- R10: `done` is high in the (1 + `extra`)th cycle after `start` for modes that do not read, and in the (4 + `extra`)th cycle for pointer modes. `busy` is high in every cycle from the one after `start` to the one before `done`, and low when `done` is high. `done` lasts one cycle. `ea` and `extra` hold their values until the next operation completes.
- R11: `start` is ignored while `busy` or `done` is high. Changes to mode, operands, indexes or `rmw` after the `start` cycle have no effect on the result.
- R12: Mode codes 9 to 15 behave as absolute: `ea` = {op_hi, op_lo}, `extra` = 0, with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an address computation; sampled only when idle |
| mode | input | 4 | Addressing mode code (see R2 to R12) |
| rmw | input | 1 | Read-modify-write access; forces the penalty in mode 4 |
| op_lo | input | DW | Operand low byte, or the zero-page base |
| op_hi | input | DW | Operand high byte for absolute modes |
| idx_x | input | DW | X index value |
| idx_y | input | DW | Y index value |
| mem_addr | output | 2*DW | Pointer read address, valid when mem_rd is high |
| mem_rd | output | 1 | Pointer read request |
| mem_data | input | DW | Read data, valid the cycle after a request |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe: ea and extra are valid |
| ea | output | 2*DW | Effective address |
| extra | output | 2 | Penalty cycles spent (index add or page crossing) |

## Verification
The bench builds the block with DW = 8, its default, which gives a 256-byte page and a 64K space. Uniformly random operand and index bytes then cross a page boundary about half the time, and zero-page sums and pointer reads often wrap, so the penalty and wrap paths of every mode are reached many times. Because page zero is only 256 bytes, the bench can model all of it in a random-filled memory that answers the pointer reads. Directed runs add the exact boundary values: a pointer at FF, a pre-index that wraps to 00, and absolute X with `rmw` set and no crossing.

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic            rmw,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  output logic [2*DW-1:0] mem_addr,
  output logic            mem_rd,
  input  logic [DW-1:0]   mem_data,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] ea,
  output logic [1:0]      extra
);
  localparam int AW = 2 * DW;
  localparam logic [3:0] M_ZP  = 4'd0;
  localparam logic [3:0] M_ZPX = 4'd1;
  localparam logic [3:0] M_ZPY = 4'd2;
  localparam logic [3:0] M_ABX = 4'd4;
  localparam logic [3:0] M_ABY = 4'd5;
  localparam logic [3:0] M_ZIN = 4'd6;
  localparam logic [3:0] M_PRE = 4'd7;
  localparam logic [3:0] M_PST = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_RLO, S_RHI, S_GOT, S_PEN, S_DONE} state_t;

  state_t        st;
  logic [DW-1:0] ptr, lo_q, yq;
  logic          post;

  logic [DW-1:0] zx, zy;
  logic [AW-1:0] base, ax, ay, pv, py;
  logic          cx, cy, cp, pen_x;

  assign zx    = op_lo + idx_x;
  assign zy    = op_lo + idx_y;
  assign base  = {op_hi, op_lo};
  assign ax    = base + AW'(idx_x);
  assign ay    = base + AW'(idx_y);
  assign cx    = ax[AW-1:DW] != op_hi;
  assign cy    = ay[AW-1:DW] != op_hi;
  assign pen_x = cx | rmw;
  assign pv    = {mem_data, lo_q};
  assign py    = pv + AW'(yq);
  assign cp    = py[AW-1:DW] != mem_data;

  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign done     = (st == S_DONE);
  assign mem_rd   = (st == S_RLO) || (st == S_RHI);
  assign mem_addr = {{DW{1'b0}}, ptr + DW'(st == S_RHI)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      lo_q  <= '0;
      yq    <= '0;
      post  <= 1'b0;
      ea    <= '0;
      extra <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          post <= (mode == M_PST);
          yq   <= idx_y;
          case (mode)
            M_ZP: begin
              ea    <= {{DW{1'b0}}, op_lo};
              extra <= 2'd0;
              st    <= S_DONE;
            end
            M_ZPX: begin
              ea    <= {{DW{1'b0}}, zx};
              extra <= 2'd1;
              st    <= S_PEN;
            end
            M_ZPY: begin
              ea    <= {{DW{1'b0}}, zy};
              extra <= 2'd1;
              st    <= S_PEN;
            end
            M_ABX: begin
              ea    <= ax;
              extra <= {1'b0, pen_x};
              st    <= pen_x ? S_PEN : S_DONE;
            end
            M_ABY: begin
              ea    <= ay;
              extra <= {1'b0, cy};
              st    <= cy ? S_PEN : S_DONE;
            end
            M_ZIN, M_PST: begin
              ptr <= op_lo;
              st  <= S_RLO;
            end
            M_PRE: begin
              ptr <= zx;
              st  <= S_RLO;
            end
            default: begin
              ea    <= base;
              extra <= 2'd0;
              st    <= S_DONE;
            end
          endcase
        end
        S_RLO: st <= S_RHI;
        S_RHI: begin
          lo_q <= mem_data;
          st   <= S_GOT;
        end
        S_GOT: begin
          if (post) begin
            ea    <= py;
            extra <= {1'b0, cp};
            st    <= cp ? S_PEN : S_DONE;
          end else begin
            ea    <= pv;
            extra <= 2'd0;
            st    <= S_DONE;
          end
        end
        S_PEN:   st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            mem_rd,
  input logic [2*DW-1:0] mem_addr,
  input logic [2*DW-1:0] ea,
  input logic [1:0]      extra
);
  localparam int AW = 2 * DW;

  p_rd_page0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[AW-1:DW] == '0));

  p_rd_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd && (mem_addr[DW-1:0] == DW'($past(mem_addr[DW-1:0]) + 1'b1)));

  p_two_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  p_rd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_ea_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ea) |-> (busy || done));

  p_extra_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (extra <= 2'd1));

  p_start_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!busy && !done));
endmodule

bind ea_sequencer ea_sequencer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .ea(ea), .extra(extra)
);

// File: tb/test_ea_sequencer.sv
`timescale 1ns/1ps
module test_ea_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        rmw = 1'b0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data = '0;
  logic        busy, done;
  logic [15:0] ea;
  logic [1:0]  extra;

  int checks = 0;
  int errors = 0;
  logic [7:0] zmem [256];

  always #10 clk = ~clk;

  ea_sequencer #(.DW(8)) i_ea_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rmw(rmw),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
    .busy(busy), .done(done), .ea(ea), .extra(extra)
  );

  always @(posedge clk) if (mem_rd) mem_data <= zmem[mem_addr[7:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void predict(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                                  input logic r, output logic [15:0] e, output logic [1:0] xt,
                                  output bit pm, output logic [7:0] p, output string t);
    logic [15:0] s, pv;
    xt = 2'd0; pm = 1'b0; p = 8'h00; e = 16'h0000;
    case (m)
      4'd0: begin e = {8'h00, lo}; t = "R2"; end
      4'd1: begin e = {8'h00, 8'(lo + x)}; xt = 2'd1; t = "R3"; end
      4'd2: begin e = {8'h00, 8'(lo + y)}; xt = 2'd1; t = "R3"; end
      4'd3: begin e = {hi, lo}; t = "R2"; end
      4'd4: begin
        s = {hi, lo} + {8'h00, x}; e = s;
        xt = 2'((s[15:8] != hi) || r); t = r ? "R5" : "R4";
      end
      4'd5: begin
        s = {hi, lo} + {8'h00, y}; e = s;
        xt = 2'(s[15:8] != hi); t = "R4";
      end
      4'd6: begin pm = 1'b1; p = lo; e = {zmem[8'(p + 1)], zmem[p]}; t = "R7"; end
      4'd7: begin pm = 1'b1; p = 8'(lo + x); e = {zmem[8'(p + 1)], zmem[p]}; t = "R8"; end
      4'd8: begin
        pm = 1'b1; p = lo; pv = {zmem[8'(p + 1)], zmem[p]};
        s = pv + {8'h00, y}; e = s; xt = 2'(s[15:8] != pv[15:8]); t = "R9";
      end
      default: begin e = {hi, lo}; t = "R12"; end
    endcase
  endfunction

  task automatic run(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                     input logic r, input bit pester);
    logic [15:0] e; logic [1:0] xt; bit pm; logic [7:0] p; string t;
    int lat, n, nrd; logic [15:0] ra [2]; bit busy_ok;
    predict(m, lo, hi, x, y, r, e, xt, pm, p, t);
    lat = 1 + int'(xt) + (pm ? 3 : 0);
    @(negedge clk);
    start = 1'b1; mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; rmw = r;
    n = 0; nrd = 0; busy_ok = 1'b1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (mem_rd) begin
        if (nrd < 2) ra[nrd] = mem_addr;
        nrd++;
      end
      if (done) begin
        n = c;
        if (busy) busy_ok = 1'b0;
        break;
      end
      if (!busy) busy_ok = 1'b0;
      start = pester;
      mode = 4'($urandom_range(0, 15));
      op_lo = 8'($urandom); op_hi = 8'($urandom);
      idx_x = 8'($urandom); idx_y = 8'($urandom); rmw = 1'($urandom);
    end
    chk(n == lat, "R10", "latency", n, lat);
    chk(busy_ok, "R10", "busy window", busy_ok, 1);
    chk(ea == e, t, "ea", ea, e);
    chk(extra == xt, t, "extra", extra, xt);
    chk(nrd == (pm ? 2 : 0), "R6", "read count", nrd, pm ? 2 : 0);
    if (pm && nrd == 2) begin
      chk(ra[0] == {8'h00, p}, "R6", "first read addr", ra[0], {8'h00, p});
      chk(ra[1] == {8'h00, 8'(p + 1)}, "R6", "second read addr", ra[1], {8'h00, 8'(p + 1)});
    end
    if (pester) begin
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk(!done && !busy, "R11", "start ignored", {busy, done}, 0);
        chk(ea == e, "R11", "ea held", ea, e);
        @(negedge clk);
      end
    end else begin
      start = 1'b0;
      @(negedge clk);
      chk(ea == e && extra == xt, "R10", "hold after done", {ea, 14'h0, extra}, {e, 14'h0, xt});
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) zmem[i] = 8'($urandom);
    zmem[8'hFF] = 8'h34; zmem[8'h00] = 8'h12; zmem[8'h01] = 8'h77;
    zmem[8'h40] = 8'hF0; zmem[8'h41] = 8'h20;
    zmem[8'h50] = 8'h10; zmem[8'h51] = 8'h20;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1", "ctrl in reset", {busy, done, mem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1", "ctrl after reset", {busy, done, mem_rd}, 0);
    chk(ea == 16'h0 && extra == 2'd0, "R1", "ea/extra after reset", {ea, extra}, 0);

    run(4'd0, 8'h80, 8'h55, 8'h00, 8'h00, 1'b0, 1'b0);
    run(4'd3, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0);
    run(4'd1, 8'hF0, 8'h00, 8'h20, 8'h00, 1'b0, 1'b0);
    run(4'd2, 8'hFF, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0);
    run(4'd5, 8'hC0, 8'h80, 8'h00, 8'h80, 1'b0, 1'b0);
    run(4'd4, 8'h10, 8'h80, 8'h05, 8'h00, 1'b0, 1'b0);
    run(4'd4, 8'h10, 8'h80, 8'h05, 8'h00, 1'b1, 1'b0);
    run(4'd5, 8'h10, 8'h80, 8'h00, 8'h05, 1'b1, 1'b0);
    run(4'd0, 8'h10, 8'h80, 8'h00, 8'h05, 1'b1, 1'b0);
    run(4'd6, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    run(4'd7, 8'hF0, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0);
    run(4'd7, 8'h30, 8'hEE, 8'h10, 8'hFF, 1'b0, 1'b0);
    run(4'd8, 8'h40, 8'h00, 8'h00, 8'h20, 1'b0, 1'b0);
    run(4'd8, 8'h50, 8'h00, 8'h00, 8'h04, 1'b0, 1'b0);
    run(4'd12, 8'h34, 8'h12, 8'h99, 8'h99, 1'b1, 1'b0);
    run(4'd8, 8'h40, 8'h00, 8'h00, 8'h20, 1'b0, 1'b1);
    run(4'd0, 8'h22, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);

    for (int i = 0; i < 400; i++)
      run(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule